// File: doc/BRIEF.md
# Split-View Mailbox Doorbell Unit

This block passes doorbell flags in one direction, from a sending agent to a receiving agent, over a configurable number of simplex channels. Each agent has its own simple memory-mapped port, and each port presents a different register view. Both views read and write the same per-channel status flags. The sender raises flags through a set register. The receiver reads the flags and drops them through a clear register. Each channel drives a level interrupt toward the receiver while any of its flags is raised.

Before it posts doorbells, the sender wakes the receiving side. It writes a wake-request register, which drives a request output. It then polls a wake-ready register. That register reflects a synchronized acknowledge input, and only while the request is still held. When the sender drops the request, the receiver is free to sleep again. The unit never forces the receiver to sleep. A read-only capability register in both views reports the channel count. All other offsets read as zero and ignore writes.

The port protocol is minimal. Each port has single-cycle read and write strobes on the rising clock edge, word-aligned byte addresses, and registered read data.

Top module: `mbx_doorbell_top`

## Requirements
- R1: During and after synchronous reset, every channel's flags are zero, every interrupt is low, the wake request is low, and both read data outputs are zero.
- R2: A sender-port write to offset 0xC inside channel window n (byte address n*0x20 + 0xC, n below the channel count) ORs the written word into channel n's flags. The result is visible at offset 0x0 of the same window in both views.
- R3: A receiver-port write to offset 0x8 inside channel window n clears exactly the flags written as 1. Flags written as 0 keep their value.
- R4: Interrupt bit n is high exactly while channel n has any flag set. It goes low on the first cycle after the write that clears the last set flag.
- R5: A read of byte address 0xF80 in either view returns the configured channel count.
- R6: A sender-port write to 0xF88 loads bit 0 of the data into the wake request. The wake request output follows on the next cycle, and the sender reads it back at 0xF88 as bit 0.
- R7: A sender read of 0xF8C returns 1 only while the wake request is held and the receiver-ready input, passed through a two-stage synchronizer, is high. Otherwise it returns 0.
- R8: Reads of unimplemented addresses return zero, and writes to them change nothing. This covers window offsets other than those above, windows at or beyond the channel count, sender writes to the clear offset, receiver writes to the set offset, and receiver accesses to 0xF88 and 0xF8C.
- R9: If a set and a clear for the same flag arrive in the same cycle, the flag ends up set.
- R10: Read data appears on the cycle after the read strobe and holds until the next read on that port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_wr | input | 1 | Sender port write strobe |
| s_rd | input | 1 | Sender port read strobe |
| s_addr | input | ADDR_W | Sender port byte address |
| s_wdata | input | FLAG_W | Sender port write data |
| s_rdata | output | FLAG_W | Sender port registered read data |
| r_wr | input | 1 | Receiver port write strobe |
| r_rd | input | 1 | Receiver port read strobe |
| r_addr | input | ADDR_W | Receiver port byte address |
| r_wdata | input | FLAG_W | Receiver port write data |
| r_rdata | output | FLAG_W | Receiver port registered read data |
| rcv_ready_i | input | 1 | Receiver wake acknowledge, asynchronous |
| wake_req_o | output | 1 | Wake request toward the receiver |
| irq_o | output | NUM_CH | Per-channel interrupt toward the receiver |

## Verification
A write that lands on an edge changes the flags at that edge. The interrupts and the wake request, which are decoded from that state, are therefore sampled at the falling edge that follows the write. Read data is registered, so each read is queued with its expected word and compared at the falling edge one cycle after its strobe. The wake-ready bit depends on two synchronizer edges plus the read register, so the bench waits three edges after changing the acknowledge input before it reads. The same-cycle set and clear case drives both ports in a single cycle and reads the flags back through the normal read path.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int WIN_BYTES = 32;

    localparam logic [4:0] OFF_STAT = 5'h00;
    localparam logic [4:0] OFF_CLR  = 5'h08;
    localparam logic [4:0] OFF_SET  = 5'h0C;

    localparam logic [31:0] ADR_CAP  = 32'h0000_0F80;
    localparam logic [31:0] ADR_WREQ = 32'h0000_0F88;
    localparam logic [31:0] ADR_WRDY = 32'h0000_0F8C;

    typedef enum logic {
        VIEW_SEND,
        VIEW_RECV
    } view_e;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_STAT,
        ACC_SET,
        ACC_CLR,
        ACC_CAP,
        ACC_WREQ,
        ACC_WRDY
    } acc_kind_e;

    typedef struct packed {
        logic req;
        logic rdy;
    } wake_state_t;

    // Classify a byte address for one view; anything unmapped is ACC_NONE.
    function automatic acc_kind_e decode_addr(input logic [31:0] a,
                                              input int num_ch,
                                              input view_e view);
        acc_kind_e k;
        k = ACC_NONE;
        if (a == ADR_CAP) begin
            k = ACC_CAP;
        end else if (a == ADR_WREQ) begin
            if (view == VIEW_SEND) k = ACC_WREQ;
        end else if (a == ADR_WRDY) begin
            if (view == VIEW_SEND) k = ACC_WRDY;
        end else if (a < 32'(num_ch) * 32'(WIN_BYTES)) begin
            if (a[4:0] == OFF_STAT)                          k = ACC_STAT;
            else if (a[4:0] == OFF_SET && view == VIEW_SEND) k = ACC_SET;
            else if (a[4:0] == OFF_CLR && view == VIEW_RECV) k = ACC_CLR;
        end
        return k;
    endfunction

endpackage

// File: rtl/mbx_status_bank.sv
module mbx_status_bank
    import mbx_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int FLAG_W = 32,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           set_en,
    input  logic [CH_W-1:0]                set_ch,
    input  logic [FLAG_W-1:0]              set_bits,
    input  logic                           clr_en,
    input  logic [CH_W-1:0]                clr_ch,
    input  logic [FLAG_W-1:0]              clr_bits,
    output logic [NUM_CH-1:0][FLAG_W-1:0]  status,
    output logic [NUM_CH-1:0]              irq
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic             set_hit;
        logic             clr_hit;
        logic [FLAG_W-1:0] nxt;

        always_comb begin
            set_hit = set_en && (set_ch == CH_W'(i));
            clr_hit = clr_en && (clr_ch == CH_W'(i));
            nxt     = status[i];
            if (clr_hit) nxt = nxt & ~clr_bits;
            // set applied last so a same-cycle set wins over the clear
            if (set_hit) nxt = nxt | set_bits;
        end

        always_ff @(posedge clk) begin
            if (rst) status[i] <= '0;
            else     status[i] <= nxt;
        end

        assign irq[i] = |status[i];
    end

endmodule

// File: rtl/mbx_wake_ctl.sv
module mbx_wake_ctl
    import mbx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_wr,
    input  logic        req_bit,
    input  logic        rcv_ready_i,
    output wake_state_t wake
);

    logic                   req_q;
    logic [SYNC_STAGES-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= 1'b0;
            sync_q <= '0;
        end else begin
            if (req_wr) req_q <= req_bit;
            sync_q <= {sync_q[SYNC_STAGES-2:0], rcv_ready_i};
        end
    end

    assign wake.req = req_q;
    assign wake.rdy = req_q & sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/mbx_view_port.sv
module mbx_view_port
    import mbx_pkg::*;
#(
    parameter int    NUM_CH = 4,
    parameter int    FLAG_W = 32,
    parameter int    ADDR_W = 12,
    parameter view_e VIEW   = VIEW_SEND,
    localparam int   CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          rd,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [NUM_CH-1:0][FLAG_W-1:0] status,
    input  wake_state_t                   wake,
    output acc_kind_e                     kind,
    output logic [CH_W-1:0]               chan,
    output logic [FLAG_W-1:0]             rdata
);

    logic [FLAG_W-1:0] rd_val;

    always_comb begin
        kind = decode_addr(32'(addr), NUM_CH, VIEW);
        chan = addr[5 +: CH_W];
    end

    always_comb begin
        rd_val = '0;
        case (kind)
            ACC_STAT: rd_val = status[chan];
            ACC_CAP:  rd_val = FLAG_W'(NUM_CH);
            ACC_WREQ: rd_val = FLAG_W'(wake.req);
            ACC_WRDY: rd_val = FLAG_W'(wake.rdy);
            default:  rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (rd) rdata <= rd_val;
    end

endmodule

// File: rtl/mbx_doorbell_top.sv
module mbx_doorbell_top
    import mbx_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int FLAG_W = 32,
    parameter int ADDR_W = 12,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s_wr,
    input  logic              s_rd,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic [FLAG_W-1:0] s_wdata,
    output logic [FLAG_W-1:0] s_rdata,
    input  logic              r_wr,
    input  logic              r_rd,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [FLAG_W-1:0] r_wdata,
    output logic [FLAG_W-1:0] r_rdata,
    input  logic              rcv_ready_i,
    output logic              wake_req_o,
    output logic [NUM_CH-1:0] irq_o
);

    logic [NUM_CH-1:0][FLAG_W-1:0] status;
    wake_state_t                   wake;
    acc_kind_e                     s_kind;
    acc_kind_e                     r_kind;
    logic [CH_W-1:0]               s_chan;
    logic [CH_W-1:0]               r_chan;

    mbx_view_port #(
        .NUM_CH(NUM_CH), .FLAG_W(FLAG_W), .ADDR_W(ADDR_W), .VIEW(VIEW_SEND)
    ) u_send (
        .clk(clk), .rst(rst), .rd(s_rd), .addr(s_addr), .status(status),
        .wake(wake), .kind(s_kind), .chan(s_chan), .rdata(s_rdata)
    );

    mbx_view_port #(
        .NUM_CH(NUM_CH), .FLAG_W(FLAG_W), .ADDR_W(ADDR_W), .VIEW(VIEW_RECV)
    ) u_recv (
        .clk(clk), .rst(rst), .rd(r_rd), .addr(r_addr), .status(status),
        .wake(wake), .kind(r_kind), .chan(r_chan), .rdata(r_rdata)
    );

    mbx_status_bank #(
        .NUM_CH(NUM_CH), .FLAG_W(FLAG_W)
    ) u_bank (
        .clk(clk), .rst(rst),
        .set_en(s_wr && s_kind == ACC_SET), .set_ch(s_chan), .set_bits(s_wdata),
        .clr_en(r_wr && r_kind == ACC_CLR), .clr_ch(r_chan), .clr_bits(r_wdata),
        .status(status), .irq(irq_o)
    );

    mbx_wake_ctl #(
        .SYNC_STAGES(2)
    ) u_wake (
        .clk(clk), .rst(rst),
        .req_wr(s_wr && s_kind == ACC_WREQ), .req_bit(s_wdata[0]),
        .rcv_ready_i(rcv_ready_i), .wake(wake)
    );

    assign wake_req_o = wake.req;

endmodule

// File: rtl/mbx_doorbell_chk.sv
module mbx_doorbell_chk #(
    parameter int NUM_CH = 4,
    parameter int FLAG_W = 32,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              s_wr,
    input logic              s_rd,
    input logic [ADDR_W-1:0] s_addr,
    input logic [FLAG_W-1:0] s_wdata,
    input logic [FLAG_W-1:0] s_rdata,
    input logic              r_wr,
    input logic              r_rd,
    input logic [ADDR_W-1:0] r_addr,
    input logic [FLAG_W-1:0] r_wdata,
    input logic [FLAG_W-1:0] r_rdata,
    input logic              wake_req_o,
    input logic [NUM_CH-1:0] irq_o
);

    localparam logic [ADDR_W-1:0] A_CAP  = ADDR_W'(12'hF80);
    localparam logic [ADDR_W-1:0] A_WREQ = ADDR_W'(12'hF88);
    localparam logic [ADDR_W-1:0] A_WRDY = ADDR_W'(12'hF8C);
    localparam logic [ADDR_W-1:0] A_HOLE = ADDR_W'(NUM_CH * 32);

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (irq_o == '0 && !wake_req_o && s_rdata == '0)); // R1

    AST_WAKE_LOADS: assert property (@(posedge clk) disable iff (rst)
        (s_wr && s_addr == A_WREQ) |=> (wake_req_o == $past(s_wdata[0]))); // R6

    AST_READY_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        (s_rd && s_addr == A_WRDY && !wake_req_o) |=> (s_rdata == '0)); // R7

    AST_CAP_SEND: assert property (@(posedge clk) disable iff (rst)
        (s_rd && s_addr == A_CAP) |=> (s_rdata == FLAG_W'(NUM_CH))); // R5

    AST_CAP_RECV: assert property (@(posedge clk) disable iff (rst)
        (r_rd && r_addr == A_CAP) |=> (r_rdata == FLAG_W'(NUM_CH))); // R5

    AST_HOLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (s_rd && s_addr >= A_HOLE && s_addr < A_CAP) |=> (s_rdata == '0)); // R8

    AST_RECV_NO_WAKE: assert property (@(posedge clk) disable iff (rst)
        (r_rd && (r_addr == A_WREQ || r_addr == A_WRDY)) |=> (r_rdata == '0)); // R8

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !s_rd |=> $stable(s_rdata)); // R10

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(i * 32 + 12);
        localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(i * 32 + 8);

        AST_SET_RAISES: assert property (@(posedge clk) disable iff (rst)
            (s_wr && s_addr == A_SET && s_wdata != '0) |=> irq_o[i]); // R9

        AST_FULL_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
            (r_wr && r_addr == A_CLR && (&r_wdata) && !(s_wr && s_addr == A_SET))
            |=> !irq_o[i]); // R4

        AST_IRQ_STAYS: assert property (@(posedge clk) disable iff (rst)
            (irq_o[i] && !(r_wr && r_addr == A_CLR)) |=> irq_o[i]); // R3

        AST_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (rst)
            (!irq_o[i] && !(s_wr && s_addr == A_SET)) |=> !irq_o[i]); // R2
    end

endmodule

bind mbx_doorbell_top mbx_doorbell_chk #(
    .NUM_CH(NUM_CH), .FLAG_W(FLAG_W), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/mbx_doorbell_top_test.sv
module mbx_doorbell_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_CH = 4;
    localparam int FLAG_W = 32;
    localparam int ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              s_wr = 1'b0, s_rd = 1'b0;
    logic [ADDR_W-1:0] s_addr = '0;
    logic [FLAG_W-1:0] s_wdata = '0;
    logic [FLAG_W-1:0] s_rdata;
    logic              r_wr = 1'b0, r_rd = 1'b0;
    logic [ADDR_W-1:0] r_addr = '0;
    logic [FLAG_W-1:0] r_wdata = '0;
    logic [FLAG_W-1:0] r_rdata;
    logic              rcv_ready_i = 1'b0;
    logic              wake_req_o;
    logic [NUM_CH-1:0] irq_o;

    mbx_doorbell_top #(.NUM_CH(NUM_CH), .FLAG_W(FLAG_W), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst(rst),
        .s_wr(s_wr), .s_rd(s_rd), .s_addr(s_addr), .s_wdata(s_wdata), .s_rdata(s_rdata),
        .r_wr(r_wr), .r_rd(r_rd), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata),
        .rcv_ready_i(rcv_ready_i), .wake_req_o(wake_req_o), .irq_o(irq_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        logic        recv_view;
        logic [31:0] exp;
        string       tag;
    } rd_item_t;

    rd_item_t sb_q[$];
    int  n_checks = 0;
    int  n_fail   = 0;
    logic rd_seen = 1'b0;
    bit  done = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: compare read data one cycle after each strobe
    always @(posedge clk) rd_seen <= (s_rd | r_rd) & ~rst;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (sb_q.size() == 0) begin
                n_checks++;
                n_fail++;
                $display("FAIL R10: read data with no expected item, actual %h expected none", s_rdata);
            end else begin
                rd_item_t it;
                it = sb_q.pop_front();
                check(it.tag, it.recv_view ? r_rdata : s_rdata, it.exp);
            end
        end
    end

    // driver tasks, each entered and left on a falling edge
    task automatic s_write(input logic [ADDR_W-1:0] a, input logic [FLAG_W-1:0] d);
        s_wr = 1'b1; s_addr = a; s_wdata = d;
        @(negedge clk);
        s_wr = 1'b0;
    endtask

    task automatic r_write(input logic [ADDR_W-1:0] a, input logic [FLAG_W-1:0] d);
        r_wr = 1'b1; r_addr = a; r_wdata = d;
        @(negedge clk);
        r_wr = 1'b0;
    endtask

    task automatic both_write(input logic [ADDR_W-1:0] sa, input logic [FLAG_W-1:0] sd,
                              input logic [ADDR_W-1:0] ra, input logic [FLAG_W-1:0] rd);
        s_wr = 1'b1; s_addr = sa; s_wdata = sd;
        r_wr = 1'b1; r_addr = ra; r_wdata = rd;
        @(negedge clk);
        s_wr = 1'b0; r_wr = 1'b0;
    endtask

    task automatic do_read(input logic recv, input logic [ADDR_W-1:0] a,
                           input logic [31:0] exp, input string tag);
        rd_item_t it;
        it.recv_view = recv; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        if (recv) begin r_rd = 1'b1; r_addr = a; end
        else      begin s_rd = 1'b1; s_addr = a; end
        @(negedge clk);
        s_rd = 1'b0; r_rd = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 irq in reset", 32'(irq_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 irq after reset", 32'(irq_o), 0);
        check("R1 wake after reset", 32'(wake_req_o), 0);
        check("R1 rdata after reset", s_rdata, 0);
        do_read(0, 12'h000, 0, "R1 ch0 status");

        do_read(0, 12'hF80, NUM_CH, "R5 cap sender");
        do_read(1, 12'hF80, NUM_CH, "R5 cap receiver");

        s_write(12'h00C, 32'h0000_0005);
        check("R2 irq ch0 raised", 32'(irq_o), 32'h1);
        s_write(12'h00C, 32'h0000_0030);
        do_read(0, 12'h000, 32'h35, "R2 OR into status sender");
        do_read(1, 12'h000, 32'h35, "R2 status receiver");
        s_write(12'h06C, 32'h8000_0000);
        check("R2 irq ch3 raised", 32'(irq_o), 32'h9);
        do_read(1, 12'h060, 32'h8000_0000, "R2 ch3 status");

        r_write(12'h008, 32'h0000_0011);
        check("R3 irq ch0 still set", 32'(irq_o), 32'h9);
        do_read(1, 12'h000, 32'h24, "R3 partial clear");
        r_write(12'h008, 32'h0000_0024);
        check("R4 irq ch0 drops", 32'(irq_o), 32'h8);

        s_write(12'h068, 32'hFFFF_FFFF);
        do_read(0, 12'h060, 32'h8000_0000, "R8 sender clear offset ignored");
        r_write(12'h02C, 32'h1);
        check("R8 receiver set offset ignored", 32'(irq_o), 32'h8);
        s_write(12'h08C, 32'h1);
        check("R8 window beyond count ignored", 32'(irq_o), 32'h8);
        do_read(0, 12'h080, 0, "R8 window beyond count reads zero");
        do_read(0, 12'h010, 0, "R8 hole offset reads zero");
        r_write(12'hF88, 32'h1);
        check("R8 receiver wake write ignored", 32'(wake_req_o), 0);

        both_write(12'h02C, 32'h3, 12'h028, 32'h1);
        do_read(1, 12'h020, 32'h3, "R9 set wins over clear");
        check("R9 irq ch1", 32'(irq_o), 32'hA);
        r_write(12'h028, 32'h3);
        check("R4 irq ch1 drops", 32'(irq_o), 32'h8);

        s_write(12'hF88, 32'h1);
        check("R6 wake request out", 32'(wake_req_o), 1);
        do_read(0, 12'hF88, 1, "R6 wake readback");
        do_read(1, 12'hF88, 0, "R8 receiver wake read zero");
        do_read(0, 12'hF8C, 0, "R7 not ready yet");
        rcv_ready_i = 1'b1;
        repeat (3) @(negedge clk);
        do_read(0, 12'hF8C, 1, "R7 ready with request");
        @(negedge clk);
        check("R10 rdata holds", s_rdata, 1);
        s_write(12'hF88, 32'h0);
        check("R6 wake request dropped", 32'(wake_req_o), 0);
        do_read(0, 12'hF8C, 0, "R7 ready needs request");
        do_read(1, 12'hF8C, 0, "R8 receiver ready read zero");

        repeat (3) @(negedge clk);
        check("R10 scoreboard drained", 32'(sb_q.size()), 0);
        done = 1;
        finish_run();
    end

endmodule